// File: doc/BRIEF.md
# Configurable Product-Term Output Macrocell

This block is one output cell of a sum-of-products logic array. It receives a group of product terms from the AND plane and turns them into a pin drive value, a tri-state enable and a feedback bit that goes back into the array. Two device-wide mode bits (`mode_g0`, `mode_g1`) and a per-cell select bit (`cell_sel`) pick one of four personalities: registered output, combinatorial output, combinatorial I/O whose driver is controlled by a product term, or dedicated input. A per-cell polarity bit (`cell_inv`) inverts the summed terms in every personality.

The cell holds the OR gate, the polarity XOR, one D flip-flop and the selection logic for terms, enable, output value and feedback. The parameter `CELL_POS` states where the cell sits in the array. The two end cells choose their feedback with the registered-device bit. The two centre cells have no feedback path in combinatorial-output or input personalities. A preload port lets a test place any state in the flip-flop directly from the pin value.

Top module: `pterm_macrocell`

## Requirements
- R1: With mode bits g0=0, g1=1, sel=0 (registered), the cell ORs all eight terms, XORs the result with `cell_inv`, and captures it on the rising `clk` edge. `drive_val` shows the captured value from the cycle after that edge, and `drive_en` follows `reg_oe`.
- R2: In the registered personality of an inner or centre cell, `fb` is the stored flip-flop bit, which is the complement of the registered `drive_val`.
- R3: With g1=1 and sel=1 (combinatorial I/O, for either g0), `drive_val` is the OR of terms 0 to 6 XOR `cell_inv`, `drive_en` equals term 7, and an inner cell feeds back `pin_in`.
- R4: With g0=1, g1=0, sel=0 (combinatorial output), `drive_val` is the OR of all eight terms XOR `cell_inv`, `drive_en` is 1, and an inner cell feeds back `neighbour_pin`.
- R5: With g0=1, g1=0, sel=1 (dedicated input), and for the unlisted codes g0=0 g1=0 and g0=1 g1=1 sel=0, `drive_en` is 0 and an inner cell feeds back `neighbour_pin`.
- R6: `cell_inv`=0 gives an active-high output and `cell_inv`=1 inverts it, in both the registered and the combinatorial personalities.
- R7: An end cell selects its feedback from {g0, sel}: 11 gives `pin_in`, 10 gives the stored flip-flop bit, and g0=0 gives `neighbour_pin`.
- R8: A centre cell drives `fb` to 0 in the combinatorial-output personality and in every input-type code. In every input-type code its driver is off.
- R9: While `rst_n` is low the flip-flop holds 0, so a registered `drive_val` is 1 whatever `cell_inv` is.
- R10: When `preload_en` is high at a rising edge, the flip-flop stores the complement of `pin_in`, so a registered `drive_val` then equals that pin value. Preload wins over normal capture and works in any personality.
- R11: Outside the registered personality, and without preload, the flip-flop keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| mode_g0 | input | 1 | Device-wide bit: 0 = device has registers |
| mode_g1 | input | 1 | Device-wide bit: selects the registered or I/O group of personalities |
| cell_sel | input | 1 | Per-cell personality select |
| cell_inv | input | 1 | Per-cell output polarity, 1 = active low |
| pterm | input | NUM_TERMS | Product terms from the AND plane; the top term can act as the enable |
| reg_oe | input | 1 | Shared enable for registered drivers |
| pin_in | input | 1 | Value present on this cell's pin |
| neighbour_pin | input | 1 | Value on the adjacent cell's pin |
| preload_en | input | 1 | Load the flip-flop from `pin_in` at the next edge |
| drive_val | output | 1 | Value the pad driver would put on the pin |
| drive_en | output | 1 | Tri-state enable for the pad driver |
| fb | output | 1 | Feedback bit returned to the AND plane |

## Verification
The clocked properties assume `preload_en` is low while reset is asserted. They also assume the mode bits change only between clock edges, so that the personality seen at an edge is the one that governed that edge's capture. The bench drives every input at the falling edge and holds `preload_en` low through each reset. The capture and hold properties count only edges whose previous edge was already out of reset, and every stimulus sequence respects this.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

  typedef enum logic [1:0] {
    PERS_REG  = 2'd0,
    PERS_CIO  = 2'd1,
    PERS_DOUT = 2'd2,
    PERS_DIN  = 2'd3
  } pers_e;

  typedef enum logic [1:0] {
    POS_INNER  = 2'd0,
    POS_END    = 2'd1,
    POS_CENTRE = 2'd2
  } pos_e;

  // Unlisted codes fall back to the input personality.
  function automatic pers_e decode_pers(input logic g0, input logic g1, input logic sel);
    case ({g0, g1, sel})
      3'b010:         return PERS_REG;
      3'b011, 3'b111: return PERS_CIO;
      3'b100:         return PERS_DOUT;
      default:        return PERS_DIN;
    endcase
  endfunction

  function automatic logic polarize(input logic sum, input logic inv);
    return sum ^ inv;
  endfunction

endpackage

// File: rtl/mc_sum_stage.sv
module mc_sum_stage
  import macrocell_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 inv,
  input  pers_e                pers,
  output logic                 comb_val,
  output logic                 term_oe
);
  localparam int OE_TERM = NUM_TERMS - 1;

  logic full_sum;
  logic part_sum;
  logic sum_sel;

  assign full_sum = |pterm;
  assign part_sum = |pterm[OE_TERM-1:0];
  assign sum_sel  = (pers == PERS_CIO) ? part_sum : full_sum;
  assign comb_val = polarize(sum_sel, inv);
  assign term_oe  = pterm[OE_TERM];

endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic preload_en,
  input  logic preload_pin,
  input  logic d_val,
  output logic q_bit
);
  // The stored bit is the complement of the value shown on the pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_bit <= 1'b0;
    else if (preload_en) q_bit <= ~preload_pin;
    else if (capture_en) q_bit <= ~d_val;
  end

  AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(preload_en)) |-> (q_bit == !$past(preload_pin))); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!capture_en && !preload_en)) |-> $stable(q_bit)); // R11

endmodule

// File: rtl/mc_feedback_sel.sv
module mc_feedback_sel
  import macrocell_pkg::*;
#(
  parameter pos_e CELL_POS = POS_INNER
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pers_e pers,
  input  logic  g0,
  input  logic  sel,
  input  logic  q_bit,
  input  logic  pin_in,
  input  logic  neighbour_pin,
  output logic  fb
);
  generate
    if (CELL_POS == POS_END) begin : g_end
      always_comb begin
        case ({g0, sel})
          2'b11:   fb = pin_in;
          2'b10:   fb = q_bit;
          default: fb = neighbour_pin;
        endcase
      end
      logic unused_pers;
      assign unused_pers = ^pers;
      AST_END_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
        !g0 |-> (fb == neighbour_pin)); // R7
    end else if (CELL_POS == POS_CENTRE) begin : g_centre
      always_comb begin
        case (pers)
          PERS_REG: fb = q_bit;
          PERS_CIO: fb = pin_in;
          default:  fb = 1'b0;
        endcase
      end
      logic unused_bits;
      assign unused_bits = g0 ^ sel ^ neighbour_pin;
      AST_CENTRE_NO_FB: assert property (@(posedge clk) disable iff (!rst_n)
        ((pers == PERS_DOUT) || (pers == PERS_DIN)) |-> (fb == 1'b0)); // R8
    end else begin : g_inner
      always_comb begin
        case (pers)
          PERS_REG: fb = q_bit;
          PERS_CIO: fb = pin_in;
          default:  fb = neighbour_pin;
        endcase
      end
      logic unused_bits;
      assign unused_bits = g0 ^ sel;
    end
  endgenerate

endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import macrocell_pkg::*;
#(
  parameter int   NUM_TERMS = 8,
  parameter pos_e CELL_POS  = POS_INNER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_g0,
  input  logic                 mode_g1,
  input  logic                 cell_sel,
  input  logic                 cell_inv,
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 reg_oe,
  input  logic                 pin_in,
  input  logic                 neighbour_pin,
  input  logic                 preload_en,
  output logic                 drive_val,
  output logic                 drive_en,
  output logic                 fb
);
  pers_e pers;
  logic  comb_val;
  logic  term_oe;
  logic  capture_en;
  logic  q_bit;

  assign pers       = decode_pers(mode_g0, mode_g1, cell_sel);
  assign capture_en = (pers == PERS_REG);

  mc_sum_stage #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .pterm    (pterm),
    .inv      (cell_inv),
    .pers     (pers),
    .comb_val (comb_val),
    .term_oe  (term_oe)
  );

  mc_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_en  (capture_en),
    .preload_en  (preload_en),
    .preload_pin (pin_in),
    .d_val       (comb_val),
    .q_bit       (q_bit)
  );

  mc_feedback_sel #(.CELL_POS(CELL_POS)) u_fb (
    .clk           (clk),
    .rst_n         (rst_n),
    .pers          (pers),
    .g0            (mode_g0),
    .sel           (cell_sel),
    .q_bit         (q_bit),
    .pin_in        (pin_in),
    .neighbour_pin (neighbour_pin),
    .fb            (fb)
  );

  always_comb begin
    case (pers)
      PERS_REG:  drive_en = reg_oe;
      PERS_CIO:  drive_en = term_oe;
      PERS_DOUT: drive_en = 1'b1;
      default:   drive_en = 1'b0;
    endcase
  end

  assign drive_val = (pers == PERS_REG) ? ~q_bit : comb_val;

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(capture_en) && $past(!preload_en) && capture_en)
      |-> (drive_val == $past(comb_val))); // R1
  AST_DOUT_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_g0 && !mode_g1 && !cell_sel) |-> drive_en); // R4
  AST_INPUT_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_g0 && !mode_g1 && cell_sel) || (!mode_g0 && !mode_g1)) |-> !drive_en); // R5
  AST_CIO_TERM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_g1 && cell_sel) |-> (drive_en == pterm[NUM_TERMS-1])); // R3
  AST_RESET_DRIVES_HIGH: assert property (@(posedge clk)
    (!rst_n && capture_en) |-> drive_val); // R9

endmodule

// File: tb/test_pterm_macrocell.sv
`timescale 1ns/1ps
module test_pterm_macrocell;
  import macrocell_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       g0 = 1'b0, g1 = 1'b1, sel = 1'b0, inv = 1'b0;
  logic [7:0] pt = 8'h00;
  logic       oe = 1'b1, pin = 1'b0, nb = 1'b0, pre = 1'b0;
  logic       dv, de, fb_in;
  logic       dv_e, de_e, fb_e;
  logic       dv_m, de_m, fb_m;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pterm_macrocell #(.NUM_TERMS(8), .CELL_POS(POS_INNER)) i_pterm_macrocell (
    .clk(clk), .rst_n(rst_n), .mode_g0(g0), .mode_g1(g1), .cell_sel(sel), .cell_inv(inv),
    .pterm(pt), .reg_oe(oe), .pin_in(pin), .neighbour_pin(nb), .preload_en(pre),
    .drive_val(dv), .drive_en(de), .fb(fb_in));

  pterm_macrocell #(.NUM_TERMS(8), .CELL_POS(POS_END)) i_pterm_macrocell_end (
    .clk(clk), .rst_n(rst_n), .mode_g0(g0), .mode_g1(g1), .cell_sel(sel), .cell_inv(inv),
    .pterm(pt), .reg_oe(oe), .pin_in(pin), .neighbour_pin(nb), .preload_en(pre),
    .drive_val(dv_e), .drive_en(de_e), .fb(fb_e));

  pterm_macrocell #(.NUM_TERMS(8), .CELL_POS(POS_CENTRE)) i_pterm_macrocell_mid (
    .clk(clk), .rst_n(rst_n), .mode_g0(g0), .mode_g1(g1), .cell_sel(sel), .cell_inv(inv),
    .pterm(pt), .reg_oe(oe), .pin_in(pin), .neighbour_pin(nb), .preload_en(pre),
    .drive_val(dv_m), .drive_en(de_m), .fb(fb_m));

  // {g0,g1,sel,inv, pterm[7:0], oe,pin,nb, exp_en,exp_val,exp_fb} for the inner cell
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [NVEC] = '{
    18'b1000_00000000_001_101,  // R4 nothing active
    18'b1000_10000000_000_110,  // R4 term 7 counts in the sum
    18'b1001_00000001_001_101,  // R4 R6 inverted
    18'b1110_10000000_010_101,  // R3 term 7 only enables
    18'b1111_00000100_001_000,  // R3 R6 driver off, pin fed back
    18'b0110_10000010_001_110,  // R3 registered device I/O
    18'b1010_11111111_101_001,  // R5 dedicated input
    18'b0000_11111111_110_000,  // R5 unlisted code 000
    18'b1100_00000000_101_001,  // R5 unlisted code 110
    18'b0011_00000001_101_001,  // R5 unlisted code 001
    18'b1111_10000000_010_111   // R3 R6 inverted empty sum
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_mode(input logic a, input logic b, input logic c);
    g0 = a; g1 = b; sel = c;
  endtask

  function automatic string tag_of(input logic a, input logic b, input logic c);
    if (b && c)           return "R3";
    if (a && !b && !c)    return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Reset state, registered personality
    repeat (3) @(negedge clk);
    chk("R9 drive high in reset", dv, 1'b1);
    chk("R1 enable from reg_oe", de, 1'b1);
    chk("R2 stored bit zero", fb_in, 1'b0);
    inv = 1'b1; #1;
    chk("R9 drive high with inverted polarity", dv, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    // Combinatorial vector walk
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {g0, g1, sel, inv, pt, oe, pin, nb} = VEC[k][17:3];
      #1;
      chk({tag_of(VEC[k][17], VEC[k][16], VEC[k][15]), " enable"}, de, VEC[k][2]);
      if (VEC[k][2]) chk({tag_of(VEC[k][17], VEC[k][16], VEC[k][15]), " value"}, dv, VEC[k][1]);
      chk({tag_of(VEC[k][17], VEC[k][16], VEC[k][15]), " feedback"}, fb_in, VEC[k][0]);
    end

    // R1 and R2: registered capture
    @(negedge clk); set_mode(0, 1, 0); inv = 0; pt = 8'h00; oe = 1; #1;
    chk("R11 held value before capture", dv, 1'b1);
    @(posedge clk); #1;
    chk("R1 captured low", dv, 1'b0);
    chk("R2 feedback is complement", fb_in, 1'b1);
    @(negedge clk); pt = 8'h10; #1;
    chk("R1 no change before edge", dv, 1'b0);
    @(posedge clk); #1;
    chk("R1 captured high", dv, 1'b1);
    chk("R2 feedback is complement", fb_in, 1'b0);
    chk("R2 centre feedback is stored bit", fb_m, 1'b0);
    @(negedge clk); oe = 0; #1;
    chk("R1 driver off by reg_oe", de, 1'b0);
    @(negedge clk); oe = 1;

    // R6 registered inversion
    inv = 1; pt = 8'h10;
    @(posedge clk); #1;
    chk("R6 registered inverted", dv, 1'b0);

    // R10 preload wins over capture
    @(negedge clk); inv = 0; pt = 8'h10; pre = 1; pin = 0;
    @(posedge clk); #1;
    chk("R10 preload over capture", dv, 1'b0);

    // R11 hold outside registered personality
    @(negedge clk); pre = 0; set_mode(1, 0, 0); pt = 8'h00; nb = 1; #1;
    chk("R4 inner feeds neighbour", fb_in, 1'b1);
    chk("R7 end cell feeds stored bit", fb_e, 1'b1);
    chk("R8 centre no feedback", fb_m, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); set_mode(0, 1, 0); pt = 8'h10; #1;
    chk("R11 register held", dv, 1'b0);
    @(posedge clk); #1;
    chk("R1 capture resumes", dv, 1'b1);

    // R10 preload in a combinatorial personality
    @(negedge clk); set_mode(1, 0, 0); pre = 1; pin = 0;
    @(posedge clk); #1;
    chk("R10 R7 preload seen on end feedback", fb_e, 1'b1);
    @(negedge clk); pre = 0; set_mode(0, 1, 0); pt = 8'h10; #1;
    chk("R10 drive equals loaded pin", dv, 1'b0);

    // R7 end cell feedback selection
    nb = 1; #1;
    chk("R7 end g0=0 neighbour high", fb_e, 1'b1);
    nb = 0; #1;
    chk("R7 end g0=0 neighbour low", fb_e, 1'b0);
    @(negedge clk); set_mode(1, 1, 1); pin = 1; nb = 0; #1;
    chk("R7 end own pin high", fb_e, 1'b1);
    pin = 0; nb = 1; #1;
    chk("R7 end own pin low", fb_e, 1'b0);
    @(negedge clk); set_mode(0, 1, 1); nb = 1; pin = 0; #1;
    chk("R7 end registered device I/O", fb_e, 1'b1);

    // R8 centre cell input codes
    @(negedge clk); set_mode(1, 0, 1); nb = 1; pt = 8'hFF; #1;
    chk("R8 centre driver off", de_m, 1'b0);
    chk("R8 centre no feedback", fb_m, 1'b0);
    chk("R5 inner neighbour feedback", fb_in, 1'b1);
    @(negedge clk); set_mode(0, 0, 0); #1;
    chk("R8 centre unlisted code off", de_m, 1'b0);
    chk("R8 centre unlisted no feedback", fb_m, 1'b0);

    // R9 reset during operation
    @(negedge clk); set_mode(0, 1, 0); pt = 8'h00;
    @(posedge clk); #1;
    chk("R1 captured low before reset", dv, 1'b0);
    @(negedge clk); rst_n = 0; #1;
    chk("R9 reset forces drive high", dv, 1'b1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule